// File: doc/BRIEF.md
# Scan-Loaded Routing Crossbar

This block routes a set of data inputs to a set of data outputs. Each output has its own multiplexer, and a select value held in a register for that output picks the input that drives it. All select fields sit in one shift chain. A configuration port of fixed width loads that chain one slice per accepted beat. The slice leaving the bottom of the chain is presented on a read port during the same beat. Shifting a new context in therefore also shifts the old one out, and the current routing can be saved, for example to pre-empt a task, in the same number of cycles that a load takes.

The multiplexers do not follow the chain while it is being shifted. They keep using an active copy of the selects. That copy is replaced only when a commit pulse arrives after a complete context has been shifted in. A static adjacency mask lists the inputs that each output may legally take. If a committed select is forbidden or out of range, that output is blocked and a sticky error flag is raised.

Top module: `xbar_scan_switch`

## Requirements
- R1: After reset, every data output is zero, `cfg_error` is 0, `cfg_ready` is 1 and `cfg_rdata` is zero.
- R2: A beat is accepted when `cfg_valid` and `cfg_ready` are both high. It shifts the chain down by CBW bits and places `cfg_wdata` in the top slice. After a full load, the first word written holds chain bits [CBW-1:0]. Output o takes its select from chain bits [o*SEL_W +: SEL_W], with SEL_W = clog2(N_IN).
- R3: A full context is NWORDS = ceil(N_OUT*SEL_W/CBW) beats. `cfg_ready` stays high until NWORDS beats have been accepted since the last taken commit. It then stays low until a commit is taken, and goes high in the following cycle.
- R4: `cfg_rdata` always shows chain bits [CBW-1:0], which is the slice that the next accepted beat shifts out. Feeding those slices back in unchanged for NWORDS beats restores the same context.
- R5: Data outputs keep the selects from the last taken commit while beats are shifted in.
- R6: A commit that arrives while `cfg_ready` is high is ignored. The routing and the beat count are left unchanged.
- R7: A committed select that is not below N_IN, or whose bit `adj_mask[o*N_IN + sel]` is 0, drives output o to zero and sets `cfg_error`.
- R8: `cfg_error` stays set through later legal commits, until reset.
- R9: For an output whose committed select s is legal, `data_out[o*DATA_W +: DATA_W]` equals `data_in[s*DATA_W +: DATA_W]` in the same cycle, starting the cycle after the commit edge.
- R10: A beat offered while `cfg_ready` is low does not change the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts at once, released through two flops |
| adj_mask | input | N_OUT*N_IN | Static legality mask; bit o*N_IN+i allows input i on output o |
| cfg_valid | input | 1 | Configuration beat offered |
| cfg_wdata | input | CBW | Slice shifted into the top of the chain |
| cfg_ready | output | 1 | Chain can accept a beat |
| cfg_rdata | output | CBW | Slice leaving the bottom of the chain |
| commit | input | 1 | Copies a full chain into the active selects |
| cfg_error | output | 1 | Sticky flag for an illegal committed select |
| data_in | input | N_IN*DATA_W | Packed input data, input i at i*DATA_W |
| data_out | output | N_OUT*DATA_W | Packed routed data, output o at o*DATA_W |

## Verification
A slip in the chain shows up on `cfg_rdata` at the next beat, because every readback slice is compared with a bench model of the chain. Any select that the multiplexers use without a taken commit shows on `data_out` in the cycle the bench samples, before the commit. A wrong beat count is visible on `cfg_ready` within one beat of the NWORDS boundary. A lost legality check shows as a non-zero blocked output or a missing `cfg_error` in the cycle after the commit edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int sel_width(input int n_in);
    return (n_in > 1) ? $clog2(n_in) : 1;
  endfunction
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/xbar_cfg_chain.sv
module xbar_cfg_chain #(
  parameter int CBW       = 8,
  parameter int NWORDS    = 12,
  parameter int CHAIN_LEN = NWORDS * CBW,
  parameter int CNT_W     = $clog2(NWORDS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat_en,
  input  logic [CBW-1:0]       beat_data,
  input  logic                 commit_take,
  output logic [CHAIN_LEN-1:0] chain_q,
  output logic                 full
);
  logic [CHAIN_LEN-1:0] chain_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 chain_en, cnt_en;

  assign full = (cnt_q == CNT_W'(NWORDS));

  // shift: new slice enters at the top, oldest slice leaves at the bottom
  always_comb begin
    chain_en = beat_en;
    if (CHAIN_LEN > CBW) chain_d = {beat_data, chain_q[CHAIN_LEN-1:CBW]};
    else                 chain_d = beat_data;
  end

  always_comb begin
    cnt_en = beat_en | commit_take;
    cnt_d  = cnt_q;
    if (commit_take)  cnt_d = '0;
    else if (beat_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (chain_en) chain_q <= chain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xbar_sel_bank.sv
module xbar_sel_bank #(
  parameter int N_IN     = 16,
  parameter int N_OUT    = 24,
  parameter int SEL_W    = 4,
  parameter int CFG_BITS = N_OUT * SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CFG_BITS-1:0]   chain_sel,
  input  logic [N_OUT*N_IN-1:0] adj_mask,
  output logic [CFG_BITS-1:0]   act_sel,
  output logic [N_OUT-1:0]      act_ok,
  output logic                  err
);
  logic [N_OUT-1:0] ok_d;
  logic             err_d, err_en;

  for (genvar o = 0; o < N_OUT; o++) begin : g_legal
    logic [SEL_W-1:0] sel;
    assign sel = chain_sel[o*SEL_W +: SEL_W];
    // out-of-range values match no input and stay illegal
    always_comb begin
      ok_d[o] = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (sel == SEL_W'(i)) ok_d[o] = adj_mask[o*N_IN + i];
      end
    end
  end

  always_comb begin
    err_en = load & ~(&ok_d);
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= '0;
      act_ok  <= '0;
    end else if (load) begin
      act_sel <= chain_sel;
      act_ok  <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err <= 1'b0;
    else if (err_en) err <= err_d;
  end
endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
  parameter int DATA_W = 1,
  parameter int N_IN   = 16,
  parameter int N_OUT  = 24,
  parameter int SEL_W  = 4
) (
  input  logic [N_IN*DATA_W-1:0]  data_in,
  input  logic [N_OUT*SEL_W-1:0]  act_sel,
  input  logic [N_OUT-1:0]        act_ok,
  output logic [N_OUT*DATA_W-1:0] data_out
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] y;
    assign sel = act_sel[o*SEL_W +: SEL_W];
    always_comb begin
      y = '0;
      if (act_ok[o]) begin
        for (int i = 0; i < N_IN; i++) begin
          if (sel == SEL_W'(i)) y = data_in[i*DATA_W +: DATA_W];
        end
      end
    end
    assign data_out[o*DATA_W +: DATA_W] = y;
  end
endmodule

// File: rtl/xbar_scan_switch.sv
module xbar_scan_switch #(
  parameter int DATA_W = 1,
  parameter int N_IN   = 16,
  parameter int N_OUT  = 24,
  parameter int CBW    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_OUT*N_IN-1:0]   adj_mask,
  input  logic                    cfg_valid,
  input  logic [CBW-1:0]          cfg_wdata,
  output logic                    cfg_ready,
  output logic [CBW-1:0]          cfg_rdata,
  input  logic                    commit,
  output logic                    cfg_error,
  input  logic [N_IN*DATA_W-1:0]  data_in,
  output logic [N_OUT*DATA_W-1:0] data_out
);
  import xbar_pkg::*;

  localparam int SEL_W     = sel_width(N_IN);
  localparam int CFG_BITS  = N_OUT * SEL_W;
  localparam int NWORDS    = ceil_div(CFG_BITS, CBW);
  localparam int CHAIN_LEN = NWORDS * CBW;
  localparam int CNT_W     = $clog2(NWORDS + 1);

  logic                 rst_core_n;
  logic [CHAIN_LEN-1:0] chain_q;
  logic                 full;
  logic                 beat_en, commit_take;
  logic [CFG_BITS-1:0]  act_sel;
  logic [N_OUT-1:0]     act_ok;

  assign cfg_ready   = ~full;
  assign beat_en     = cfg_valid & ~full;
  assign commit_take = commit & full;
  assign cfg_rdata   = chain_q[CBW-1:0];

  xbar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  xbar_cfg_chain #(
    .CBW (CBW), .NWORDS (NWORDS), .CHAIN_LEN (CHAIN_LEN), .CNT_W (CNT_W)
  ) u_chain (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .beat_en     (beat_en),
    .beat_data   (cfg_wdata),
    .commit_take (commit_take),
    .chain_q     (chain_q),
    .full        (full)
  );

  xbar_sel_bank #(
    .N_IN (N_IN), .N_OUT (N_OUT), .SEL_W (SEL_W), .CFG_BITS (CFG_BITS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (commit_take),
    .chain_sel (chain_q[CFG_BITS-1:0]),
    .adj_mask  (adj_mask),
    .act_sel   (act_sel),
    .act_ok    (act_ok),
    .err       (cfg_error)
  );

  xbar_out_mux #(
    .DATA_W (DATA_W), .N_IN (N_IN), .N_OUT (N_OUT), .SEL_W (SEL_W)
  ) u_mux (
    .data_in  (data_in),
    .act_sel  (act_sel),
    .act_ok   (act_ok),
    .data_out (data_out)
  );
endmodule

// File: rtl/xbar_scan_switch_chk.sv
module xbar_scan_switch_chk #(
  parameter int DATA_W = 1,
  parameter int N_IN   = 16,
  parameter int N_OUT  = 24,
  parameter int CBW    = 8
) (
  input logic                    clk,
  input logic                    rst_core_n,
  input logic                    cfg_valid,
  input logic                    cfg_ready,
  input logic                    commit,
  input logic                    cfg_error,
  input logic [N_OUT*DATA_W-1:0] data_out,
  input logic [N_OUT*xbar_pkg::sel_width(N_IN)-1:0] act_sel,
  input logic [N_OUT-1:0]        act_ok
);
  assert_ready_back_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (commit && !cfg_ready) |=> cfg_ready);

  assert_ready_fall_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(cfg_ready) |-> $past(cfg_valid));

  assert_hold_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(commit && !cfg_ready) |=> $stable(act_sel) && $stable(act_ok));

  assert_partial_commit_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (commit && cfg_ready && !cfg_valid) |=> cfg_ready && $stable(act_sel));

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_error |=> cfg_error);

  for (genvar o = 0; o < N_OUT; o++) begin : g_blk
    assert_blocked_zero_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
      !act_ok[o] |-> (data_out[o*DATA_W +: DATA_W] == '0));
  end
endmodule

bind xbar_scan_switch xbar_scan_switch_chk #(
  .DATA_W (DATA_W), .N_IN (N_IN), .N_OUT (N_OUT), .CBW (CBW)
) u_chk (.*);

// File: tb/xbar_scan_switch_bench.sv
`timescale 1ns/1ps
module xbar_scan_switch_bench;
  localparam int DATA_W    = 1;
  localparam int N_IN      = 16;
  localparam int N_OUT     = 24;
  localparam int CBW       = 8;
  localparam int SEL_W     = $clog2(N_IN);
  localparam int CFG_BITS  = N_OUT * SEL_W;
  localparam int NWORDS    = (CFG_BITS + CBW - 1) / CBW;
  localparam int CHAIN_LEN = NWORDS * CBW;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [N_OUT*N_IN-1:0]   adj_mask;
  logic                    cfg_valid;
  logic [CBW-1:0]          cfg_wdata;
  logic                    cfg_ready;
  logic [CBW-1:0]          cfg_rdata;
  logic                    commit;
  logic                    cfg_error;
  logic [N_IN*DATA_W-1:0]  data_in;
  logic [N_OUT*DATA_W-1:0] data_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [CHAIN_LEN-1:0] mdl_chain;
  logic [CFG_BITS-1:0]  mdl_act;
  logic                 mdl_any;
  logic                 mdl_err;
  int                   mdl_cnt;

  always #2.5 clk = ~clk;

  xbar_scan_switch #(.DATA_W(DATA_W), .N_IN(N_IN), .N_OUT(N_OUT), .CBW(CBW)) u_xbar_scan_switch (
    .clk(clk), .rst_n(rst_n), .adj_mask(adj_mask), .cfg_valid(cfg_valid),
    .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
    .commit(commit), .cfg_error(cfg_error), .data_in(data_in), .data_out(data_out));

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int o, input int s);
    return (s < N_IN) && adj_mask[o*N_IN + s];
  endfunction

  function automatic logic [N_OUT*DATA_W-1:0] exp_out(input logic [CFG_BITS-1:0] act,
                                                      input logic [N_IN*DATA_W-1:0] din);
    logic [N_OUT*DATA_W-1:0] r = '0;
    for (int o = 0; o < N_OUT; o++) begin
      int s = int'(act[o*SEL_W +: SEL_W]);
      if (mdl_any && legal(o, s)) r[o*DATA_W +: DATA_W] = din[s*DATA_W +: DATA_W];
    end
    return r;
  endfunction

  function automatic logic [CHAIN_LEN-1:0] rand_ctx();
    logic [CHAIN_LEN-1:0] c = '0;
    for (int o = 0; o < N_OUT; o++) begin
      int s = int'($urandom_range(N_IN - 1));
      while (!legal(o, s)) s = (s + 1) % N_IN;
      c[o*SEL_W +: SEL_W] = SEL_W'(s);
    end
    return c;
  endfunction

  // one beat; R4 readback and R3 ready checked before the edge, R2 model updated
  task automatic beat(input logic [CBW-1:0] w, input bit recirc);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_wdata = recirc ? cfg_rdata : w;
    #1;
    check(cfg_rdata == mdl_chain[CBW-1:0], "R4 rdata", 256'(cfg_rdata), 256'(mdl_chain[CBW-1:0]));
    check(cfg_ready == (mdl_cnt < NWORDS), "R3 ready", 256'(cfg_ready), 256'(mdl_cnt < NWORDS));
    if (mdl_cnt < NWORDS) begin
      mdl_chain = {cfg_wdata, mdl_chain[CHAIN_LEN-1:CBW]};
      mdl_cnt++;
    end
    @(posedge clk);
    #1 cfg_valid = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk);
    commit = 1'b1;
    if (mdl_cnt == NWORDS) begin
      mdl_act = mdl_chain[CFG_BITS-1:0];
      mdl_any = 1'b1;
      mdl_cnt = 0;
      for (int o = 0; o < N_OUT; o++)
        if (!legal(o, int'(mdl_act[o*SEL_W +: SEL_W]))) mdl_err = 1'b1;
    end
    @(posedge clk);
    #1 commit = 1'b0;
  endtask

  task automatic check_outs(input string req, input int pats);
    for (int p = 0; p < pats; p++) begin
      @(negedge clk);
      data_in = N_IN'($urandom);
      #1;
      check(data_out == exp_out(mdl_act, data_in), req, 256'(data_out), 256'(exp_out(mdl_act, data_in)));
    end
    check(cfg_error == mdl_err, "R7/R8 error flag", 256'(cfg_error), 256'(mdl_err));
  endtask

  task automatic load_ctx(input logic [CHAIN_LEN-1:0] c);
    for (int k = 0; k < NWORDS; k++) beat(c[k*CBW +: CBW], 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CHAIN_LEN-1:0] ctx;
    int bad_sel;
    void'($urandom(32'd7149));
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        adj_mask[o*N_IN + i] = ((i*3 + o) % 7) != 0;
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_wdata = '0; commit = 1'b0; data_in = '1;
    mdl_chain = '0; mdl_act = '0; mdl_any = 1'b0; mdl_err = 1'b0; mdl_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(data_out == '0, "R1 data_out", 256'(data_out), 0);
    check(cfg_error == 1'b0, "R1 cfg_error", 256'(cfg_error), 0);
    check(cfg_ready == 1'b1, "R1 cfg_ready", 256'(cfg_ready), 1);
    check(cfg_rdata == '0, "R1 cfg_rdata", 256'(cfg_rdata), 0);

    // R6: commit after a partial load is ignored
    ctx = rand_ctx();
    for (int k = 0; k < 3; k++) beat(ctx[k*CBW +: CBW], 1'b0);
    do_commit();
    check_outs("R6 partial commit ignored", 3);
    #1 check(cfg_ready == 1'b1, "R6 ready kept", 256'(cfg_ready), 1);
    for (int k = 3; k < NWORDS; k++) beat(ctx[k*CBW +: CBW], 1'b0);
    // R10: beat while full is dropped (model leaves chain alone)
    beat(8'hA5, 1'b0);
    check_outs("R5 hold before commit", 3);
    do_commit();
    check_outs("R9 route ctx", 4);

    // random legal contexts, swapping old out as new goes in (R2, R4, R5, R9)
    for (int n = 0; n < 15; n++) begin
      load_ctx(rand_ctx());
      check_outs("R5 old routing during load", 2);
      do_commit();
      check_outs("R9 random ctx", 3);
    end

    // R7: forbidden select on output 2
    ctx = rand_ctx();
    bad_sel = 0;
    while (legal(2, bad_sel)) bad_sel++;
    ctx[2*SEL_W +: SEL_W] = SEL_W'(bad_sel);
    load_ctx(ctx);
    do_commit();
    check_outs("R7 blocked output", 4);
    #1 check(data_out[2*DATA_W +: DATA_W] == '0, "R7 output 2 zero", 256'(data_out), 0);

    // R8: legal context afterwards, error stays
    load_ctx(rand_ctx());
    do_commit();
    check_outs("R8 sticky error", 3);

    // R4: recirculate readback, routing unchanged
    for (int k = 0; k < NWORDS; k++) beat('0, 1'b1);
    do_commit();
    check_outs("R4 recirculated ctx", 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule